// File: doc/BRIEF.md
# Multi-Pattern Memory Traffic Generator

This block is a self-checking traffic source for one memory port. An elaboration-time parameter picks one of five access patterns. A bulk pattern writes the whole region and then reads it back. A write-only pattern and a read-only pattern each use ascending addresses. An alternating pattern issues one write and then reads the same burst before moving on. A random pattern follows the same write-then-read pairing, but it takes each burst address from a pseudo-random sequence. Write data comes from a 31-bit maximal-length LFSR. A second copy of that LFSR, seeded the same way, produces the data each read response is expected to carry. Any difference between the two is latched as an error.

Commands use two valid/ready channels, one for writes (address and data together) and one for reads. Read responses come back in order on a valid-only channel. Each burst is one beat of `BURST_BYTES`. A second parameter selects the run style. In bounded operation the block issues a fixed number of bursts, waits for all read responses and then raises `done`. In looping operation it sweeps the address region over and over. The reset input is asynchronous and active low, and the block releases it internally on a clock edge.

Top module: `mem_traffic_gen`

## Requirements
- R1: `MODE` selects bulk (0), write-only (1), read-only (2), alternating (3) or random (4). The default is bulk. `done`, `err_flag`, `err_count`, `wr_valid` and `rd_valid` are 0 while reset is held.
- R2: Bulk mode, bounded: the n-th write (n from 0) goes to `BASE_ADDR + 32*n` for n = 0 to NUM_BURSTS-1. After the last write, reads go to the same addresses in the same order. No read is issued before the final write handshake.
- R3: Write-only mode issues only writes, to ascending addresses `BASE_ADDR + 32*n`. `rd_valid` is never raised.
- R4: Read-only mode issues only reads, to ascending addresses `BASE_ADDR + 32*n`. Returned data is not compared, so `err_flag` and `err_count` stay 0 whatever the data is.
- R5: Alternating mode: write n goes to `BASE_ADDR + 32*n`. The next read targets that same address and is raised only after the write handshake. The next write follows that read's handshake.
- R6: Random mode: pair n uses address `BASE_ADDR + (S_n & (WIN_BYTES-1) & ~(BURST_BYTES-1))`. S_0 = `ADDR_SEED`, and S advances once per pair using the LFSR of R7. The read of each pair targets the address its write used.
- R7: Write n carries the value D_n, zero-extended. D_0 = `DATA_SEED`, and D_(k+1) = {D_k[29:0], D_k[30] ^ D_k[27]} (polynomial x^31 + x^28 + 1).
- R8: In every mode except read-only, read response k is compared with D_k. Each mismatch sets `err_flag` and increments `err_count`. Both are sticky until reset.
- R9: `err_count` saturates at 2^ERR_W - 1.
- R10: In bounded operation the block issues NUM_BURSTS bursts per direction that the mode uses. `done` stays 0 until all of them have completed their handshakes and all read responses have arrived. It rises within two cycles after that and then stays high.
- R11: In looping operation, after the last burst of the WIN_BYTES/BURST_BYTES region the address returns to `BASE_ADDR` and the pattern repeats. `done` is never raised.
- R12: Every issued address lies in [BASE_ADDR, BASE_ADDR + WIN_BYTES) and is a multiple of BURST_BYTES.
- R13: A raised command valid holds its address and data steady until ready is seen. The write and read valids are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Write command accepted |
| wr_addr | output | AW | Write burst byte address |
| wr_data | output | DW | Write burst data |
| rd_valid | output | 1 | Read command valid |
| rd_ready | input | 1 | Read command accepted |
| rd_addr | output | AW | Read burst byte address |
| rd_resp_valid | input | 1 | In-order read response valid |
| rd_resp_data | input | DW | Read response data |
| done | output | 1 | Bounded run finished |
| err_flag | output | 1 | Sticky data mismatch flag |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
A command is due in the cycle its valid is seen together with ready. The memory model changes its readies and response valid only on the falling edge. At that same edge it records the handshakes the next rising edge will complete, so every address and data check is made on the exact accepted beat. A read response is presented no earlier than the falling edge after its command's handshake. The mismatch result is registered once, so the error outputs are read only after the run has drained. `done` gets its two-cycle allowance and is checked several cycles after the last response. A `done` seen before every handshake and response has been counted fails at once.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  typedef enum logic [2:0] {
    TG_BULK   = 3'd0,
    TG_WRONLY = 3'd1,
    TG_RDONLY = 3'd2,
    TG_ALT    = 3'd3,
    TG_RAND   = 3'd4
  } tg_mode_e;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_WR    = 3'd1,
    ST_RD    = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } tg_state_e;

  localparam int LFSR_W = 31;
endpackage

// File: rtl/tgen_rst_sync.sv
module tgen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tgen_lfsr.sv
module tgen_lfsr #(
  parameter logic [tgen_pkg::LFSR_W-1:0] SEED = 31'h1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  output logic [tgen_pkg::LFSR_W-1:0]   state
);
  logic [tgen_pkg::LFSR_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = {state_q[29:0], state_q[30] ^ state_q[27]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tgen_check.sv
module tgen_check #(
  parameter int                          DW    = 32,
  parameter int                          ERR_W = 16,
  parameter bit                          CHECK = 1'b1,
  parameter logic [tgen_pkg::LFSR_W-1:0] SEED  = 31'h1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resp_valid,
  input  logic [DW-1:0]    resp_data,
  output logic             err_flag,
  output logic [ERR_W-1:0] err_count
);
  logic [tgen_pkg::LFSR_W-1:0] exp_state;
  logic                        mism;
  logic                        flag_q, flag_d;
  logic [ERR_W-1:0]            cnt_q, cnt_d;

  tgen_lfsr #(.SEED(SEED)) u_exp (
    .clk(clk), .rst_n(rst_n), .step(resp_valid), .state(exp_state)
  );

  assign mism = CHECK && resp_valid && (resp_data != DW'(exp_state));

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (mism) begin
      flag_d = 1'b1;
      if (cnt_q != {ERR_W{1'b1}}) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (mism) begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign err_flag  = flag_q;
  assign err_count = cnt_q;

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r9_count_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_count >= $past(err_count));
  a_r8_count_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != '0) |-> err_flag);
endmodule

// File: rtl/tgen_seq.sv
module tgen_seq #(
  parameter tgen_pkg::tg_mode_e MODE        = tgen_pkg::TG_BULK,
  parameter bit                 LOOP        = 1'b0,
  parameter int                 AW          = 32,
  parameter logic [AW-1:0]      BASE_ADDR   = '0,
  parameter int                 WIN_BYTES   = 8192,
  parameter int                 BURST_BYTES = 32,
  parameter int                 NUM_BURSTS  = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [tgen_pkg::LFSR_W-1:0]   rnd_state,
  output logic                          rnd_step,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic                          rd_valid,
  input  logic                          rd_ready,
  output logic [AW-1:0]                 cmd_addr,
  input  logic                          resp_valid,
  output logic                          done
);
  import tgen_pkg::*;

  localparam int WIN_BURSTS = WIN_BYTES / BURST_BYTES;
  localparam int SWEEP      = LOOP ? WIN_BURSTS : NUM_BURSTS;
  localparam int IDX_W      = (SWEEP > 1) ? $clog2(SWEEP) : 1;
  localparam int OFF_W      = $clog2(BURST_BYTES);
  localparam int OUT_W      = IDX_W + 2;
  localparam bit PAIRED     = (MODE == TG_ALT) || (MODE == TG_RAND);

  tg_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             wv_q, wv_d, rv_q, rv_d;
  logic [OUT_W-1:0] outst_q, outst_d;
  logic             load, last, wr_hs, rd_hs, en;

  function automatic logic [AW-1:0] burst_addr(input logic [IDX_W-1:0] i);
    if (MODE == TG_RAND)
      return BASE_ADDR + (AW'(rnd_state) & AW'(WIN_BYTES - 1) & ~AW'(BURST_BYTES - 1));
    return BASE_ADDR + (AW'(i) << OFF_W);
  endfunction

  assign wr_hs = wv_q && wr_ready;
  assign rd_hs = rv_q && rd_ready;
  assign last  = (idx_q == IDX_W'(SWEEP - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    wv_d    = wv_q;
    rv_d    = rv_q;
    load    = 1'b0;
    unique case (state_q)
      ST_START: begin
        load   = 1'b1;
        idx_d  = '0;
        addr_d = burst_addr('0);
        if (MODE == TG_RDONLY) begin state_d = ST_RD; rv_d = 1'b1; end
        else                   begin state_d = ST_WR; wv_d = 1'b1; end
      end
      ST_WR: if (wr_hs) begin
        wv_d = 1'b0;
        if (PAIRED) begin
          state_d = ST_RD;
          rv_d    = 1'b1;
        end else if (!last) begin
          idx_d = idx_q + 1'b1; load = 1'b1; addr_d = burst_addr(idx_q + 1'b1); wv_d = 1'b1;
        end else if (MODE == TG_BULK) begin
          idx_d = '0; load = 1'b1; addr_d = burst_addr('0); state_d = ST_RD; rv_d = 1'b1;
        end else if (LOOP) begin
          idx_d = '0; load = 1'b1; addr_d = burst_addr('0); wv_d = 1'b1;
        end else begin
          state_d = ST_DRAIN;
        end
      end
      ST_RD: if (rd_hs) begin
        rv_d = 1'b0;
        if (!last) begin
          idx_d = idx_q + 1'b1; load = 1'b1; addr_d = burst_addr(idx_q + 1'b1);
          if (PAIRED) begin state_d = ST_WR; wv_d = 1'b1; end
          else        rv_d = 1'b1;
        end else if (LOOP) begin
          idx_d = '0; load = 1'b1; addr_d = burst_addr('0);
          if (MODE == TG_RDONLY) rv_d = 1'b1;
          else begin state_d = ST_WR; wv_d = 1'b1; end
        end else begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: if (outst_q == '0) state_d = ST_DONE;
      default: ;
    endcase
  end

  always_comb begin
    outst_d = outst_q;
    if (rd_hs && !resp_valid)      outst_d = outst_q + 1'b1;
    else if (!rd_hs && resp_valid) outst_d = outst_q - 1'b1;
  end

  assign en = (state_q != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      idx_q   <= '0;
      addr_q  <= '0;
      wv_q    <= 1'b0;
      rv_q    <= 1'b0;
      outst_q <= '0;
    end else if (en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      wv_q    <= wv_d;
      rv_q    <= rv_d;
      outst_q <= outst_d;
    end
  end

  assign rnd_step = load && (MODE == TG_RAND);
  assign wr_valid = wv_q;
  assign rd_valid = rv_q;
  assign cmd_addr = addr_q;
  assign done     = (state_q == ST_DONE);

  a_r13_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(cmd_addr)));
  a_r13_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(cmd_addr)));
  a_r13_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));
  a_r12_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |-> (cmd_addr >= BASE_ADDR && (cmd_addr - BASE_ADDR) < AW'(WIN_BYTES)));
  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid || rd_valid) |-> ((cmd_addr & AW'(BURST_BYTES - 1)) == '0));
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  if (PAIRED) begin : g_pair_chk
    a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(wr_valid && wr_ready));
  end
  if (LOOP) begin : g_loop_chk
    a_r11_never_done: assert property (@(posedge clk) disable iff (!rst_n) !done);
  end
  if (MODE == TG_WRONLY) begin : g_wo_chk
    a_r3_no_read: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid);
  end
endmodule

// File: rtl/mem_traffic_gen.sv
module mem_traffic_gen #(
  parameter tgen_pkg::tg_mode_e          MODE        = tgen_pkg::TG_BULK,
  parameter bit                          LOOP        = 1'b0,
  parameter int                          AW          = 32,
  parameter int                          DW          = 32,
  parameter logic [AW-1:0]               BASE_ADDR   = '0,
  parameter int                          WIN_BYTES   = 8192,
  parameter int                          BURST_BYTES = 32,
  parameter int                          NUM_BURSTS  = 256,
  parameter int                          ERR_W       = 16,
  parameter logic [tgen_pkg::LFSR_W-1:0] DATA_SEED   = 31'h0000_0001,
  parameter logic [tgen_pkg::LFSR_W-1:0] ADDR_SEED   = 31'h2AB5_C3D1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_resp_valid,
  input  logic [DW-1:0]    rd_resp_data,
  output logic             done,
  output logic             err_flag,
  output logic [ERR_W-1:0] err_count
);
  import tgen_pkg::*;

  logic              rst_n_i;
  logic [LFSR_W-1:0] data_state, rnd_state;
  logic              rnd_step;
  logic [AW-1:0]     cmd_addr;

  tgen_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  tgen_lfsr #(.SEED(DATA_SEED)) u_wdata (
    .clk(clk), .rst_n(rst_n_i), .step(wr_valid && wr_ready), .state(data_state)
  );

  tgen_lfsr #(.SEED(ADDR_SEED)) u_raddr (
    .clk(clk), .rst_n(rst_n_i), .step(rnd_step), .state(rnd_state)
  );

  tgen_seq #(
    .MODE(MODE), .LOOP(LOOP), .AW(AW), .BASE_ADDR(BASE_ADDR),
    .WIN_BYTES(WIN_BYTES), .BURST_BYTES(BURST_BYTES), .NUM_BURSTS(NUM_BURSTS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_i), .rnd_state(rnd_state), .rnd_step(rnd_step),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .cmd_addr(cmd_addr), .resp_valid(rd_resp_valid), .done(done)
  );

  tgen_check #(
    .DW(DW), .ERR_W(ERR_W), .CHECK(MODE != TG_RDONLY), .SEED(DATA_SEED)
  ) u_chk (
    .clk(clk), .rst_n(rst_n_i), .resp_valid(rd_resp_valid), .resp_data(rd_resp_data),
    .err_flag(err_flag), .err_count(err_count)
  );

  assign wr_addr = cmd_addr;
  assign rd_addr = cmd_addr;
  assign wr_data = DW'(data_state);

  a_r13_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_valid && !wr_ready) |=> $stable(wr_data));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n_i |-> (!wr_valid && !rd_valid && !done && !err_flag));
endmodule

// File: tb/tb_mem_traffic_gen.sv
`timescale 1ns/1ps

module tb_port #(
  parameter tgen_pkg::tg_mode_e MODE    = tgen_pkg::TG_BULK,
  parameter bit                 LOOP    = 1'b0,
  parameter logic [31:0]        BASE    = 32'h0,
  parameter int                 WIN     = 8192,
  parameter int                 NW      = 256,
  parameter int                 NR      = 256,
  parameter int                 CORRUPT = 0,
  parameter int                 CIDX    = 0,
  parameter int                 SEED    = 1
) (
  input  logic        clk,
  input  logic        wr_valid,
  input  logic [31:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_valid,
  input  logic [31:0] rd_addr,
  input  logic        done,
  output logic        wr_ready,
  output logic        rd_ready,
  output logic        resp_valid,
  output logic [31:0] resp_data,
  output int          checks,
  output int          fails,
  output int          wcnt,
  output int          rcnt
);
  import tgen_pkg::*;
  localparam int SW = LOOP ? WIN / 32 : 256;

  logic [31:0] mem [256];
  logic [31:0] q [$];
  logic [30:0] dexp, aexp;
  logic [31:0] last_wa;
  int          respcnt;
  bit          done_seen;

  function automatic logic [30:0] nxt(input logic [30:0] s);
    return {s[29:0], s[30] ^ s[27]};
  endfunction
  function automatic logic [31:0] lin(input int n);
    return BASE + 32'((n % SW) * 32);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s mode=%0d actual=%0h expected=%0h", tag, MODE, act, exp);
    end
  endtask

  initial begin
    checks = 0; fails = 0; wcnt = 0; rcnt = 0; respcnt = 0; done_seen = 0;
    wr_ready = 0; rd_ready = 0; resp_valid = 0; resp_data = '0;
    dexp = 31'h1; aexp = 31'h2AB5_C3D1; last_wa = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    void'($urandom(SEED));
    forever begin
      @(negedge clk);
      if (resp_valid) begin void'(q.pop_front()); respcnt++; end
      resp_valid = (q.size() != 0) && ($urandom % 4 != 0);
      if (resp_valid) begin
        resp_data = q[0];
        if (CORRUPT == 2 || (CORRUPT == 1 && respcnt == CIDX)) resp_data[0] = ~resp_data[0];
      end
      wr_ready = ($urandom % 4 != 0);
      rd_ready = ($urandom % 4 != 0);
      if (wr_valid && wr_ready) begin
        logic [31:0] ea;
        if (MODE == TG_RAND) begin
          ea = BASE + ({1'b0, aexp} & 32'(WIN - 1) & ~32'd31);
          aexp = nxt(aexp);
        end else ea = lin(wcnt);
        chk(MODE != TG_RDONLY, "R4 write in read-only", 1, 0);
        chk(wr_addr == ea, (MODE == TG_RAND) ? "R6 write addr" :
            (MODE == TG_ALT) ? "R5 write addr" : (MODE == TG_WRONLY) ? "R3 write addr" : "R2 write addr",
            wr_addr, ea);
        chk(wr_data == {1'b0, dexp}, "R7 write data", wr_data, {1'b0, dexp});
        if (MODE == TG_BULK && !LOOP) chk(rcnt == 0, "R2 read before writes done", rcnt, 0);
        if (MODE == TG_ALT || MODE == TG_RAND) chk(rcnt == wcnt, "R5 write before prior read", rcnt, wcnt);
        mem[((wr_addr - BASE) >> 5) % 256] = wr_data;
        last_wa = wr_addr;
        dexp = nxt(dexp);
        wcnt++;
      end
      if (rd_valid && rd_ready) begin
        chk(MODE != TG_WRONLY, "R3 read in write-only", 1, 0);
        if (MODE == TG_ALT || MODE == TG_RAND) begin
          chk(rd_addr == last_wa, (MODE == TG_RAND) ? "R6 read addr" : "R5 read addr", rd_addr, last_wa);
          chk(rcnt == wcnt - 1, "R5 read after its write", rcnt, wcnt - 1);
        end else begin
          chk(rd_addr == lin(rcnt), (MODE == TG_RDONLY) ? "R4 read addr" : "R2 read addr",
              rd_addr, lin(rcnt));
          if (MODE == TG_BULK && !LOOP) chk(wcnt == NW, "R2 reads after all writes", wcnt, NW);
        end
        q.push_back(mem[((rd_addr - BASE) >> 5) % 256]);
        rcnt++;
      end
      if (done && !done_seen) begin
        done_seen = 1;
        if (LOOP) chk(0, "R11 done in loop", 1, 0);
        else begin
          chk(wcnt == NW, "R10 done early writes", wcnt, NW);
          chk(respcnt == NR, "R10 done early responses", respcnt, NR);
        end
      end
    end
  end
endmodule

module tb_lane #(
  parameter tgen_pkg::tg_mode_e MODE    = tgen_pkg::TG_ALT,
  parameter bit                 LOOP    = 1'b0,
  parameter logic [31:0]        BASE    = 32'h0,
  parameter int                 WIN     = 8192,
  parameter int                 NW      = 256,
  parameter int                 NR      = 256,
  parameter int                 CORRUPT = 0,
  parameter int                 ERR_W   = 16,
  parameter int                 SEED    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        done,
  output logic        eflag,
  output logic [15:0] ecnt,
  output int          checks,
  output int          fails,
  output int          wcnt,
  output int          rcnt
);
  logic        wv, wr, rv, rr, pv;
  logic [31:0] wa, wd, ra, pd;
  logic [ERR_W-1:0] ec;

  mem_traffic_gen #(.MODE(MODE), .LOOP(LOOP), .BASE_ADDR(BASE), .WIN_BYTES(WIN), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_ready(wr), .wr_addr(wa), .wr_data(wd),
    .rd_valid(rv), .rd_ready(rr), .rd_addr(ra), .rd_resp_valid(pv), .rd_resp_data(pd),
    .done(done), .err_flag(eflag), .err_count(ec)
  );
  assign ecnt = 16'(ec);

  tb_port #(.MODE(MODE), .LOOP(LOOP), .BASE(BASE), .WIN(WIN), .NW(NW), .NR(NR),
            .CORRUPT(CORRUPT), .CIDX(0), .SEED(SEED)) u_port (
    .clk(clk), .wr_valid(wv), .wr_addr(wa), .wr_data(wd), .rd_valid(rv), .rd_addr(ra),
    .done(done), .wr_ready(wr), .rd_ready(rr), .resp_valid(pv), .resp_data(pd),
    .checks(checks), .fails(fails), .wcnt(wcnt), .rcnt(rcnt)
  );
endmodule

module tb_mem_traffic_gen;
  import tgen_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        wv, wr, rv, rr, pv, done, eflag;
  logic [31:0] wa, wd, ra, pd;
  logic [15:0] ecnt;
  int          c0, f0, w0, r0;

  mem_traffic_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_ready(wr), .wr_addr(wa), .wr_data(wd),
    .rd_valid(rv), .rd_ready(rr), .rd_addr(ra), .rd_resp_valid(pv), .rd_resp_data(pd),
    .done(done), .err_flag(eflag), .err_count(ecnt)
  );
  tb_port #(.MODE(TG_BULK), .CORRUPT(1), .CIDX(100), .SEED(11)) u_port (
    .clk(clk), .wr_valid(wv), .wr_addr(wa), .wr_data(wd), .rd_valid(rv), .rd_addr(ra),
    .done(done), .wr_ready(wr), .rd_ready(rr), .resp_valid(pv), .resp_data(pd),
    .checks(c0), .fails(f0), .wcnt(w0), .rcnt(r0)
  );

  logic        d1, d2, d3, d4, d5, d6, e1, e2, e3, e4, e5, e6;
  logic [15:0] n1, n2, n3, n4, n5, n6;
  int          c1, c2, c3, c4, c5, c6, f1, f2, f3, f4, f5, f6;
  int          w1, w2, w3, w4, w5, w6, r1, r2, r3, r4, r5, r6;

  tb_lane #(.MODE(TG_WRONLY), .NR(0), .SEED(21)) u_wo (
    .clk(clk), .rst_n(rst_n), .done(d1), .eflag(e1), .ecnt(n1), .checks(c1), .fails(f1), .wcnt(w1), .rcnt(r1));
  tb_lane #(.MODE(TG_RDONLY), .NW(0), .BASE(32'h0004_0000), .SEED(31)) u_ro (
    .clk(clk), .rst_n(rst_n), .done(d2), .eflag(e2), .ecnt(n2), .checks(c2), .fails(f2), .wcnt(w2), .rcnt(r2));
  tb_lane #(.MODE(TG_ALT), .BASE(32'h0010_0000), .SEED(41)) u_alt (
    .clk(clk), .rst_n(rst_n), .done(d3), .eflag(e3), .ecnt(n3), .checks(c3), .fails(f3), .wcnt(w3), .rcnt(r3));
  tb_lane #(.MODE(TG_RAND), .BASE(32'h0020_0000), .SEED(51)) u_rnd (
    .clk(clk), .rst_n(rst_n), .done(d4), .eflag(e4), .ecnt(n4), .checks(c4), .fails(f4), .wcnt(w4), .rcnt(r4));
  tb_lane #(.MODE(TG_ALT), .CORRUPT(2), .ERR_W(2), .SEED(61)) u_sat (
    .clk(clk), .rst_n(rst_n), .done(d5), .eflag(e5), .ecnt(n5), .checks(c5), .fails(f5), .wcnt(w5), .rcnt(r5));
  tb_lane #(.MODE(TG_BULK), .LOOP(1'b1), .WIN(128), .NW(0), .NR(0), .SEED(71)) u_loop (
    .clk(clk), .rst_n(rst_n), .done(d6), .eflag(e6), .ecnt(n6), .checks(c6), .fails(f6), .wcnt(w6), .rcnt(r6));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(!wv && !rv, "R1 reset valids", {wv, rv}, 0);
    chk(!done && !eflag && ecnt == 0, "R1 reset status", {done, eflag, ecnt}, 0);
    chk(!d5 && !e5, "R1 reset status lane", {d5, e5}, 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!(done && d1 && d2 && d3 && d4 && d5) && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 40000, "watchdog", cyc, 40000);
    repeat (5) @(negedge clk);
    chk(done && w0 == 256 && r0 == 256, "R2 R10 bulk counts", {w0, r0}, {32'd256, 32'd256});
    chk(eflag && ecnt == 16'd1, "R8 R1 single corruption", ecnt, 1);
    chk(d1 && w1 == 256 && r1 == 0, "R3 R10 write-only counts", {w1, r1}, {32'd256, 32'd0});
    chk(!e1 && n1 == 0, "R8 write-only no errors", n1, 0);
    chk(d2 && r2 == 256 && w2 == 0, "R4 R10 read-only counts", {w2, r2}, {32'd0, 32'd256});
    chk(!e2 && n2 == 0, "R4 read-only data ignored", n2, 0);
    chk(d3 && w3 == 256 && r3 == 256 && !e3, "R5 alternating clean", {w3, r3}, {32'd256, 32'd256});
    chk(d4 && w4 == 256 && r4 == 256 && !e4, "R6 random clean", {w4, r4}, {32'd256, 32'd256});
    chk(e5 && n5 == 16'd3, "R9 saturation", n5, 3);
    chk(!d6 && w6 > 8 && r6 > 4, "R11 loop wraps", w6, 9);
    checks += c0 + c1 + c2 + c3 + c4 + c5 + c6;
    fails  += f0 + f1 + f2 + f3 + f4 + f5 + f6;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule